// File: doc/BRIEF.md
# Channel Impulse Windowing and Noise Estimator

This block sits between the inverse and forward transforms of a pilot-based channel estimator. It receives the 128-point complex channel impulse response one tap per valid cycle and returns the same stream. Taps whose position in the block is inside the guard-interval span (the first 16 taps) pass unchanged. Every later tap is forced to zero, so the next forward transform produces a channel estimate with the noise outside the guard interval removed.

In the same pass the block adds up the power I² + Q² of the taps it discarded. When the block's last tap arrives, the block scales that sum by a fixed multiply-and-shift into a noise-variance estimate for the equalizer weight computation. A start flag marks the first tap of each block. A block interrupted by a new start is dropped, and the block raises an error pulse.

Top module: `cir_window_noise`

## Requirements
- R1: For every cycle with `in_valid` high, the next cycle has `out_valid` high, and `out_valid` is low otherwise. Samples leave in arrival order with a fixed latency of one cycle.
- R2: A tap inside an open block whose index is below GI_LEN (16) appears on `out_i`/`out_q` with its value unchanged. The index is 0 for a sample carrying `in_start` and counts up by one per valid sample after that.
- R3: A tap inside an open block whose index is GI_LEN or more (16 to 127) appears on the outputs as zero on both I and Q.
- R4: A valid sample without `in_start` that arrives while no block is open is output as zero. It does not change the tap count or the noise sum.
- R5: One cycle after the tap with index NPTS-1 (127) is accepted, `nv_valid` pulses high for exactly one cycle. `nv_value` changes only in that cycle and holds its value otherwise.
- R6: `nv_value` equals floor(S × NOISE_MUL / 2^NOISE_SHR) truncated to ACC_W bits. S is the sum of I² + Q² over the block's taps 16 to 127, with I and Q read as two's-complement numbers. The defaults are NOISE_MUL = 73 and NOISE_SHR = 13, which gives roughly 1/112.
- R7: `in_start` sets the tap index to 0 and clears the noise sum. If `in_start` arrives while a block is still open, `blk_err` pulses high for one cycle in the next cycle. The partial block gives no `nv_valid`, and the new block is processed normally.
- R8: While reset is held, and after it, until the first input is accepted, `out_valid`, `out_start`, `nv_valid`, `blk_err`, `out_i`, `out_q` and `nv_value` are all zero.
- R9: `out_start` is high exactly with the output of a sample that carried `in_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| in_valid | input | 1 | Input tap present |
| in_start | input | 1 | Input tap is the first of a block |
| in_i | input | DW | Input tap, real part, two's complement |
| in_q | input | DW | Input tap, imaginary part, two's complement |
| out_valid | output | 1 | Windowed tap present |
| out_start | output | 1 | Windowed tap is the first of a block |
| out_i | output | DW | Windowed tap, real part |
| out_q | output | DW | Windowed tap, imaginary part |
| nv_valid | output | 1 | One-cycle pulse: new noise variance |
| nv_value | output | ACC_W | Scaled noise variance, held between updates |
| blk_err | output | 1 | One-cycle pulse: block cut short by a new start |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 128 taps, a 16-tap window and a 73/2^13 scale. At these values the full-size block and the real window boundary at taps 15 and 16 are both exercised. A block of most-negative samples drives the 39-bit noise sum toward its top bits and tests the signed squaring. Random blocks with idle gaps, stray samples outside a block, and a block cut short by a new start show that the tap index survives pauses and that only complete blocks report a noise value.

// File: rtl/cirw_pkg.sv
package cirw_pkg;
  typedef enum logic {
    BLK_IDLE = 1'b0,
    BLK_OPEN = 1'b1
  } blk_state_e;
endpackage

// File: rtl/cirw_rst_sync.sv
module cirw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cirw_tap_ctrl.sv
module cirw_tap_ctrl #(
  parameter int NPTS   = 128,
  parameter int GI_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_start,
  output logic tap_keep,
  output logic tap_oob,
  output logic tap_first,
  output logic tap_last,
  output logic err_pulse
);
  import cirw_pkg::*;

  localparam int IW = (NPTS > 2) ? $clog2(NPTS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NPTS - 1);
  localparam logic [IW:0]   GI_IDX   = (IW+1)'(GI_LEN);

  blk_state_e state_q, state_d;
  logic [IW-1:0] cnt_q, cnt_d;
  logic err_q, err_d;
  logic [IW-1:0] cur_idx;
  logic in_blk;

  // Index of the tap now at the input
  always_comb begin
    cur_idx   = in_start ? '0 : cnt_q;
    in_blk    = in_valid && (in_start || (state_q == BLK_OPEN));
    tap_first = in_valid && in_start;
    tap_keep  = in_blk && ({1'b0, cur_idx} < GI_IDX);
    tap_oob   = in_blk && ({1'b0, cur_idx} >= GI_IDX);
    tap_last  = in_blk && (cur_idx == LAST_IDX);
  end

  // Next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    err_d   = in_valid && in_start && (state_q == BLK_OPEN);
    if (in_valid) begin
      if (in_start) begin
        state_d = BLK_OPEN;
        cnt_d   = IW'(1);
      end else if (state_q == BLK_OPEN) begin
        cnt_d = cnt_q + IW'(1);
      end
      if (tap_last) begin
        state_d = BLK_IDLE;
        cnt_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BLK_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
    end
  end

  assign err_pulse = err_q;
endmodule

// File: rtl/cirw_window_gate.sv
module cirw_window_gate #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic          tap_keep,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  output logic          out_valid,
  output logic          out_start,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q
);
  logic          vld_q, vld_d;
  logic          sop_q, sop_d;
  logic [DW-1:0] i_q, i_d, q_q, q_d;
  logic          data_en;

  always_comb begin
    vld_d   = in_valid;
    sop_d   = in_valid && in_start;
    data_en = in_valid;
    i_d     = tap_keep ? in_i : '0;
    q_d     = tap_keep ? in_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sop_q <= 1'b0;
      i_q   <= '0;
      q_q   <= '0;
    end else begin
      vld_q <= vld_d;
      sop_q <= sop_d;
      if (data_en) begin
        i_q <= i_d;
        q_q <= q_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_start = sop_q;
  assign out_i     = i_q;
  assign out_q     = q_q;
endmodule

// File: rtl/cirw_noise_acc.sv
module cirw_noise_acc #(
  parameter int DW        = 16,
  parameter int ACC_W     = 39,
  parameter int NOISE_MUL = 73,
  parameter int NOISE_SHR = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    in_i,
  input  logic [DW-1:0]    in_q,
  input  logic             tap_first,
  input  logic             tap_oob,
  input  logic             tap_last,
  output logic             nv_valid,
  output logic [ACC_W-1:0] nv_value
);
  localparam int PW    = 2 * DW;
  localparam int MUL_W = $clog2(NOISE_MUL + 1);
  localparam int PROD_W = ACC_W + MUL_W;

  logic signed [PW-1:0] sq_i, sq_q;
  logic [PW-1:0]        tap_pwr;
  logic [ACC_W-1:0]     acc_q, acc_d, acc_sum;
  logic [PROD_W-1:0]    scaled;
  logic                 nvv_q, nvv_d;
  logic [ACC_W-1:0]     nv_q, nv_d;

  // Power of the tap at the input
  always_comb begin
    sq_i    = $signed(in_i) * $signed(in_i);
    sq_q    = $signed(in_q) * $signed(in_q);
    tap_pwr = $unsigned(sq_i) + $unsigned(sq_q);
  end

  // Running sum including the present tap, then the scale step
  always_comb begin
    acc_sum = tap_first ? '0 : acc_q;
    if (tap_oob) begin
      acc_sum = acc_sum + ACC_W'(tap_pwr);
    end
    scaled = PROD_W'(acc_sum) * PROD_W'(NOISE_MUL);
  end

  always_comb begin
    acc_d = acc_sum;
    nvv_d = tap_last;
    nv_d  = nv_q;
    if (tap_last) begin
      nv_d  = ACC_W'(scaled >> NOISE_SHR);
      acc_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      nvv_q <= 1'b0;
      nv_q  <= '0;
    end else begin
      acc_q <= acc_d;
      nvv_q <= nvv_d;
      if (tap_last) begin
        nv_q <= nv_d;
      end
    end
  end

  assign nv_valid = nvv_q;
  assign nv_value = nv_q;
endmodule

// File: rtl/cir_window_noise.sv
module cir_window_noise #(
  parameter int DW        = 16,
  parameter int NPTS      = 128,
  parameter int GI_LEN    = 16,
  parameter int NOISE_MUL = 73,
  parameter int NOISE_SHR = 13,
  parameter int ACC_W     = 2 * DW + $clog2(NPTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic [DW-1:0]    in_i,
  input  logic [DW-1:0]    in_q,
  output logic             out_valid,
  output logic             out_start,
  output logic [DW-1:0]    out_i,
  output logic [DW-1:0]    out_q,
  output logic             nv_valid,
  output logic [ACC_W-1:0] nv_value,
  output logic             blk_err
);
  logic rst_n_int;
  logic tap_keep, tap_oob, tap_first, tap_last;

  cirw_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  cirw_tap_ctrl #(
    .NPTS  (NPTS),
    .GI_LEN(GI_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .in_valid (in_valid),
    .in_start (in_start),
    .tap_keep (tap_keep),
    .tap_oob  (tap_oob),
    .tap_first(tap_first),
    .tap_last (tap_last),
    .err_pulse(blk_err)
  );

  cirw_window_gate #(
    .DW(DW)
  ) u_gate (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .in_valid (in_valid),
    .in_start (in_start),
    .tap_keep (tap_keep),
    .in_i     (in_i),
    .in_q     (in_q),
    .out_valid(out_valid),
    .out_start(out_start),
    .out_i    (out_i),
    .out_q    (out_q)
  );

  cirw_noise_acc #(
    .DW       (DW),
    .ACC_W    (ACC_W),
    .NOISE_MUL(NOISE_MUL),
    .NOISE_SHR(NOISE_SHR)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .in_i     (in_i),
    .in_q     (in_q),
    .tap_first(tap_first),
    .tap_oob  (tap_oob),
    .tap_last (tap_last),
    .nv_valid (nv_valid),
    .nv_value (nv_value)
  );
endmodule

// File: rtl/cir_window_noise_chk.sv
module cir_window_noise_chk #(
  parameter int ACC_W = 39
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_start,
  input logic             out_valid,
  input logic             out_start,
  input logic             nv_valid,
  input logic [ACC_W-1:0] nv_value,
  input logic             blk_err
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9
  sop_marks_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);

  // R5
  nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_valid |-> $stable(nv_value));

  // R5
  nv_after_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_valid |-> $past(in_valid));

  // R7
  err_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_err |-> $past(in_valid && in_start));
endmodule

bind cir_window_noise cir_window_noise_chk #(.ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_start (in_start),
  .out_valid(out_valid),
  .out_start(out_start),
  .nv_valid (nv_valid),
  .nv_value (nv_value),
  .blk_err  (blk_err)
);

// File: tb/sim_cir_window_noise.sv
module sim_cir_window_noise;
  localparam int DW    = 16;
  localparam int NPTS  = 128;
  localparam int GI    = 16;
  localparam int MULV  = 73;
  localparam int SHR   = 13;
  localparam int ACC_W = 2 * DW + $clog2(NPTS);

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_start;
  logic [DW-1:0] in_i, in_q;
  logic out_valid, out_start, nv_valid, blk_err;
  logic [DW-1:0] out_i, out_q;
  logic [ACC_W-1:0] nv_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench reference state
  bit b_open = 0;
  int b_cnt  = 0;
  longint unsigned b_acc = 0;
  longint unsigned b_nv  = 0;

  always #2 clk = ~clk;

  cir_window_noise u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_start(out_start),
    .out_i(out_i), .out_q(out_q), .nv_valid(nv_valid), .nv_value(nv_value),
    .blk_err(blk_err)
  );

  function automatic longint unsigned tap_power(logic [DW-1:0] a, logic [DW-1:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    return longint'(sa * sa + sb * sb);
  endfunction

  function automatic longint unsigned scale_nv(longint unsigned s);
    longint unsigned mask = (64'd1 << ACC_W) - 1;
    return ((s * MULV) >> SHR) & mask;
  endfunction

  task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle and check the registered results one edge later
  task automatic step(bit v, bit s, logic [DW-1:0] di, logic [DW-1:0] dq);
    bit in_blk, keep, oob, last, e_err;
    int idx;
    @(negedge clk);
    in_valid = v; in_start = s; in_i = di; in_q = dq;
    e_err  = v && s && b_open;
    in_blk = v && (s || b_open);
    idx    = s ? 0 : b_cnt;
    keep   = in_blk && idx < GI;
    oob    = in_blk && idx >= GI;
    last   = in_blk && idx == NPTS - 1;
    if (v && s) b_acc = 0;
    if (oob) b_acc += tap_power(di, dq);
    if (last) b_nv = scale_nv(b_acc);
    if (v) begin
      if (s) begin b_open = 1; b_cnt = 1; end
      else if (b_open) b_cnt++;
      if (last) begin b_open = 0; b_cnt = 0; end
    end
    @(posedge clk); #1;
    check(out_valid == v, "R1 out_valid", out_valid, v);
    if (v) begin
      check(out_start == s, "R9 out_start", out_start, s);
      if (keep) begin
        check(out_i == di && out_q == dq, "R2 pass tap", {out_i, out_q}, {di, dq});
      end else if (oob) begin
        check(out_i == 0 && out_q == 0, "R3 zero tap", {out_i, out_q}, 0);
      end else begin
        check(out_i == 0 && out_q == 0, "R4 stray tap", {out_i, out_q}, 0);
      end
    end
    check(nv_valid == last, "R5 nv_valid", nv_valid, last);
    if (last) check(nv_value == b_nv, "R6 nv_value", nv_value, b_nv);
    else check(nv_value == b_nv, "R5 nv hold", nv_value, b_nv);
    check(blk_err == e_err, "R7 blk_err", blk_err, e_err);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0);
  endtask

  task automatic rand_block(int len, int gap_pct);
    for (int k = 0; k < len; k++) begin
      while (($urandom % 100) < gap_pct) step(0, 0, DW'($urandom), DW'($urandom));
      step(1, k == 0, DW'($urandom), DW'($urandom));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; in_valid = 0; in_start = 0; in_i = 0; in_q = 0;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check({out_valid, out_start, nv_valid, blk_err} == 0, "R8 flags in reset",
          {out_valid, out_start, nv_valid, blk_err}, 0);
    check(out_i == 0 && out_q == 0 && nv_value == 0, "R8 data in reset",
          {out_i, out_q}, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    check({out_valid, nv_valid, blk_err, nv_value} == 0, "R8 after release",
          {out_valid, nv_valid, blk_err}, 0);

    // R4 stray samples before any block
    for (int k = 0; k < 5; k++) step(1, 0, DW'(1000 + k), DW'(7));
    // directed: full-scale negative block, R6 corner
    for (int k = 0; k < NPTS; k++) step(1, k == 0, 16'h8000, 16'h8000);
    idle(2);
    // directed: ramp exposing index 15/16 boundary, R2 and R3
    for (int k = 0; k < NPTS; k++) step(1, k == 0, DW'(k + 1), DW'(-(k + 1)));
    // R4 stray after block end
    step(1, 0, 16'h1234, 16'h5678);
    // R7 block cut short, then completed block
    rand_block(40, 0);
    rand_block(NPTS, 0);
    // R7 start on the very last index position of a cut block
    rand_block(NPTS - 1, 10);
    rand_block(NPTS, 10);
    // random blocks with gaps
    for (int b = 0; b < 8; b++) begin
      rand_block(NPTS, 25);
      idle($urandom % 4);
    end
    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule